// File: doc/BRIEF.md
# Modular Divider over a Fixed Prime

This block computes a quotient in the finite field of integers modulo a prime P that is fixed when the design is built. Given a dividend x and a nonzero divisor y, it returns z with y·z ≡ x (mod P).

The inverse of y is formed by raising y to the power P-2 with left-to-right square-and-multiply. One final modular product with x then gives the quotient. Every modular product comes from a bit-serial double-and-add multiplier that reduces after each step, so no value ever reaches 2P. The latency depends only on the bits of P-2, so for a given build every operation takes the same number of cycles.

The interface has plain control pins and no stream. A one-cycle `start` pulse launches an operation when the block is not computing. `done` rises when `z_out` is valid, and both hold until the next accepted `start`. A `start` that arrives during a computation is dropped. The host keeps x below P and keeps y between 1 and P-1.

Top module: `fermat_divider`

## Requirements
- R1: For any x in [0, P-1] and y in [1, P-1], when `done` is high `z_out` is below P and (y·z_out) mod P equals x.
- R2: A dividend of x = 0 yields z_out = 0 for every legal divisor.
- R3: A divisor of y = 1 yields z_out = x, and a divisor of y = P-1 yields z_out = (P - x) mod P.
- R4: After a synchronous active-high reset, `done` is 0 and `z_out` is 0.
- R5: Let N = K + popcount(P-2) + 1 be the number of modular products. If `start` is sampled at rising edge 0, `done` becomes 1 right after rising edge N·(K+2) and is 0 at every edge before it.
- R6: While `done` is high and `start` stays low, `done` remains high and `z_out` does not change.
- R7: A `start` pulse that arrives while an operation is in progress is ignored. It changes neither the latency nor the result of the running operation.
- R8: A `start` sampled while `done` is high is accepted, and `done` is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch pulse, sampled only when idle or finished |
| x_in | input | K | Dividend, below P |
| y_in | input | K | Divisor, 1 to P-1 |
| z_out | output | K | Quotient x/y mod P, valid while done is high |
| done | output | 1 | High from completion until the next accepted start |

## Verification
Two events can fall in the same cycle: a new `start` and the held result of the last operation. The bench launches each new operation directly from the finished state. It then checks that `done` drops one cycle later and that the new quotient and latency are right. A second collision happens when a `start` arrives during a running exponentiation. The bench injects a pulse with different operands partway through a run. It passes only if the original quotient appears after the exact latency. A checker counts cycles from each accepted launch and compares the count at the rise of `done`.

// File: rtl/fermat_div_pkg.sv
package fermat_div_pkg;
  // Operand width and the fixed prime modulus (P < 2**K).
  parameter int unsigned K = 8;
  parameter int unsigned P = 251;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQR,
    ST_MULY,
    ST_MULX,
    ST_DONE
  } fdiv_state_t;
endpackage

// File: rtl/fdiv_modmul.sv
// Bit-serial modular multiplier: scans op_a from its MSB, doubles the
// partial sum, adds op_b on a one bit, and reduces after each step.
module fdiv_modmul #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 251
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod,
  output logic         rdy
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [W:0]  MODV = (W+1)'(M);
  localparam logic [CW-1:0] CNT_LOAD = CW'(W);

  logic [W-1:0]  a_q, b_q, acc_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    dbl, red1, sum, red2;

  always_comb begin
    dbl  = {acc_q, 1'b0};
    red1 = (dbl >= MODV) ? dbl - MODV : dbl;
    sum  = red1 + (a_q[W-1] ? {1'b0, b_q} : '0);
    red2 = (sum >= MODV) ? sum - MODV : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      rdy   <= 1'b0;
    end else if (go) begin
      a_q   <= op_a;
      b_q   <= op_b;
      acc_q <= '0;
      cnt_q <= CNT_LOAD;
      rdy   <= 1'b0;
    end else begin
      rdy <= (cnt_q == CW'(1));
      if (cnt_q != '0) begin
        acc_q <= red2[W-1:0];
        a_q   <= {a_q[W-2:0], 1'b0};
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign prod = acc_q;
endmodule

// File: rtl/fdiv_ctrl.sv
// Sequencer: scans exponent P-2 MSB first (square, then multiply by y on
// a one bit), then multiplies the inverse by x.
module fdiv_ctrl
  import fermat_div_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned M = 251
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         mul_rdy,
  input  logic [W-1:0] mul_prod,
  output logic         mul_go,
  output logic [W-1:0] mul_a,
  output logic [W-1:0] mul_b,
  output logic [W-1:0] z_out,
  output logic         done
);
  localparam int unsigned BW  = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] EXP = W'(M - 2);
  localparam logic [BW-1:0] TOP_BIT = BW'(W - 1);

  fdiv_state_t   state_q;
  logic [W-1:0]  acc_q, x_q, y_q;
  logic [BW-1:0] bit_q;
  logic          accept;

  assign accept = start && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    mul_a = acc_q;
    unique case (state_q)
      ST_MULY: mul_b = y_q;
      ST_MULX: mul_b = x_q;
      default: mul_b = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      bit_q   <= '0;
      mul_go  <= 1'b0;
      z_out   <= '0;
      done    <= 1'b0;
    end else begin
      mul_go <= 1'b0;
      if (accept) begin
        x_q     <= x_in;
        y_q     <= y_in;
        acc_q   <= W'(1);
        bit_q   <= TOP_BIT;
        done    <= 1'b0;
        mul_go  <= 1'b1;
        state_q <= ST_SQR;
      end else if (mul_rdy) begin
        unique case (state_q)
          ST_SQR: begin
            acc_q  <= mul_prod;
            mul_go <= 1'b1;
            if (EXP[bit_q])        state_q <= ST_MULY;
            else if (bit_q == '0)  state_q <= ST_MULX;
            else                   bit_q   <= bit_q - BW'(1);
          end
          ST_MULY: begin
            acc_q  <= mul_prod;
            mul_go <= 1'b1;
            if (bit_q == '0) state_q <= ST_MULX;
            else begin
              bit_q   <= bit_q - BW'(1);
              state_q <= ST_SQR;
            end
          end
          ST_MULX: begin
            z_out   <= mul_prod;
            done    <= 1'b1;
            state_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fermat_divider.sv
module fermat_divider
  import fermat_div_pkg::*;
#(
  parameter int unsigned W = K,
  parameter int unsigned M = P
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] z_out,
  output logic         done
);
  logic         mul_go, mul_rdy;
  logic [W-1:0] mul_a, mul_b, mul_prod;

  fdiv_ctrl #(.W(W), .M(M)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
    .mul_rdy(mul_rdy), .mul_prod(mul_prod), .mul_go(mul_go),
    .mul_a(mul_a), .mul_b(mul_b), .z_out(z_out), .done(done)
  );

  fdiv_modmul #(.W(W), .M(M)) mul_i (
    .clk(clk), .rst(rst), .go(mul_go), .op_a(mul_a), .op_b(mul_b),
    .prod(mul_prod), .rdy(mul_rdy)
  );
endmodule

// File: rtl/fermat_divider_chk.sv
module fermat_divider_chk #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 251
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] z_out,
  input logic         done
);
  function automatic int unsigned ones(input int unsigned v);
    int unsigned c = 0;
    for (int i = 0; i < 32; i++) c += (v >> i) & 1;
    return c;
  endfunction

  localparam int unsigned LAT = (W + ones(M - 2) + 1) * (W + 2);

  logic        run_q;
  logic [31:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start && (!run_q || done)) begin
      run_q <= 1'b1;
      cnt_q <= 32'd1;
    end else if (run_q && done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 32'd1;
    end
  end

  assert_z_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (z_out < W'(M)));

  // R5, R7: completion after exactly LAT cycles from the accepted launch
  assert_exact_latency_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (run_q && cnt_q == LAT + 1));

  assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(z_out)));

  assert_relaunch_drops_done_R8: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);
endmodule

bind fermat_divider fermat_divider_chk #(.W(W), .M(M)) chk_i (
  .clk(clk), .rst(rst), .start(start), .z_out(z_out), .done(done)
);

// File: tb/fermat_divider_tb_top.sv
`timescale 1ns/1ps
module fermat_divider_tb_top;
  import fermat_div_pkg::*;

  localparam int unsigned W = K;
  localparam int unsigned M = P;

  function automatic int unsigned ones(input int unsigned v);
    int unsigned c = 0;
    for (int i = 0; i < 32; i++) c += (v >> i) & 1;
    return c;
  endfunction

  localparam int unsigned LAT = (W + ones(M - 2) + 1) * (W + 2);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] x_i = '0, y_i = '0;
  logic [W-1:0] z_out;
  logic         done;

  int n_tests = 0, n_fail = 0;
  int unsigned seed = 32'd12345;

  always #4 clk = ~clk;

  fermat_divider dut_i (
    .clk(clk), .rst(rst), .start(start), .x_in(x_i), .y_in(y_i),
    .z_out(z_out), .done(done)
  );

  function automatic longint unsigned pw(input longint unsigned b, input longint unsigned e);
    longint unsigned r = 1, bb = b % M, ee = e;
    while (ee != 0) begin
      if (ee[0]) r = (r * bb) % M;
      bb = (bb * bb) % M;
      ee = ee >> 1;
    end
    return r;
  endfunction

  function automatic longint unsigned ref_div(input longint unsigned x, input longint unsigned y);
    return (x * pw(y, M - 2)) % M;
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int unsigned xv, input int unsigned yv, input bit inject,
                        input string req);
    int cnt;
    logic [W-1:0] zh;
    @(negedge clk);
    x_i = W'(xv); y_i = W'(yv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    check("R8 done low after launch", done, 0);
    while (!done && cnt < int'(LAT) + 20) begin
      if (inject && cnt == 20) begin
        start = 1'b1;
        x_i = W'((xv + 1) % M);
        y_i = W'(1);
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    // R5 latency (also R7 when a stray pulse was injected)
    check(inject ? "R7 latency with stray start" : "R5 latency", cnt - 1, LAT);
    check(req, z_out, ref_div(xv, yv));
    check("R1 y*z mod P", (longint'(yv) * z_out) % M, xv);
    zh = z_out;
    repeat (3) @(negedge clk);
    check("R6 done held", done, 1);
    check("R6 z held", z_out, zh);
  endtask

  initial begin : watchdog
    repeat (199000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 done after reset", done, 0);
    check("R4 z after reset", z_out, 0);

    run_op(0, 7, 0, "R2 x=0");
    run_op(0, M - 1, 0, "R2 x=0 y=P-1");
    run_op(M - 1, 1, 0, "R3 y=1");
    run_op(123 % M, 1, 0, "R3 y=1");
    run_op(5, M - 1, 0, "R3 y=P-1");
    run_op(M - 1, M - 1, 0, "R3 y=P-1");
    run_op(0, 1, 0, "R2 x=0 y=1");
    run_op(77 % M, 3, 1, "R7 result with stray start");

    for (int i = 0; i < 1000; i++) begin
      int unsigned xv, yv;
      xv = $urandom % M;
      yv = 1 + ($urandom % (M - 1));
      run_op(xv, yv, 0, "R1 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule